// File: doc/BRIEF.md
# Two-Way Latched Bus Transceiver

This block passes bytes between two ports, A and B, without inverting them. It has two storage banks, one for each direction. Each bank is set up by three active-low controls: an enable, a load gate and a drive gate. A bank can follow its source port, freeze a value, and later present that value to the opposite port. It presents the value only when that direction's enable and drive gate are both low. At all other times the destination side is released.

The core runs on one system clock. A bank takes in its source port on every clock edge at which its enable and load gate are both low, and it keeps its contents at every other edge. This gives a one-cycle version of a transparent latch. When the load gate rises, the bank keeps the value sampled in the last cycle before the rise.

Each port has a data-out vector and one drive bit. When the drive bit is low, the data-out vector is forced to zero. An optional pad wrapper maps each pair onto a tri-state inout bus. A contention output flags every cycle in which both directions drive together.

Top module: `xcvr_top`

## Requirements
- R1: A synchronous active-high `rst` clears both banks to zero. After reset, enabling a drive presents 0x00.
- R2: When `a2b_ce_n` and `a2b_le_n` are both low at a clock edge, the A-to-B bank stores `a_in` from that edge. The stored value appears on `b_out` after the edge whenever B is driven.
- R3: When `a2b_ce_n` is high or `a2b_le_n` is high at an edge, the A-to-B bank keeps its contents whatever `a_in` does.
- R4: When `a2b_le_n` rises while `a2b_ce_n` is low, the bank keeps the `a_in` value sampled at the last edge before the rise.
- R5: `b_drive` is 1 exactly when `a2b_ce_n` and `a2b_oe_n` are both low. When `b_drive` is 1, `b_out` equals the A-to-B bank. When it is 0, `b_out` is 0x00.
- R6: While `a2b_le_n` is high, an enabled B driver shows the held value even as `a_in` changes.
- R7: The B-to-A direction obeys R2 to R6 with `b2a_ce_n`, `b2a_le_n` and `b2a_oe_n` as controls, `b_in` as source and `a_out`/`a_drive` as driven port.
- R8: `contend` is 1 in exactly those cycles in which `a_drive` and `b_drive` are both 1.
- R9: Loading or holding one bank never changes the other bank.
- R10: Toggling a drive gate has no effect on the stored value of its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Data sampled from port A |
| b_in | input | 8 | Data sampled from port B |
| a2b_ce_n | input | 1 | A-to-B enable, active low |
| a2b_le_n | input | 1 | A-to-B load gate, active low |
| a2b_oe_n | input | 1 | A-to-B drive gate, active low |
| b2a_ce_n | input | 1 | B-to-A enable, active low |
| b2a_le_n | input | 1 | B-to-A load gate, active low |
| b2a_oe_n | input | 1 | B-to-A drive gate, active low |
| a_out | output | 8 | Value for port A, zero when not driven |
| a_drive | output | 1 | Port A driver active |
| b_out | output | 8 | Value for port B, zero when not driven |
| b_drive | output | 1 | Port B driver active |
| contend | output | 1 | Both directions drive in this cycle |

## Verification
Two functions can act in the same cycle: a bank loading from its source, and that same bank's driver presenting the stored value. In that cycle the old value must show until the edge, and the new value only after it. The bench provokes this by holding enable, load gate and drive gate low while the source changes on every cycle. A second case is a load in one direction while the other direction drives with its load gate high. A behavioural model is updated at each edge and compared half a cycle later. A pass therefore shows the one-cycle lag, the freeze on the rising load gate, and that neither bank disturbs the other.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int DIRS    = 2;
    localparam int IDX_A2B = 0;
    localparam int IDX_B2A = 1;

    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctl_t;

    function automatic logic ctl_loads(dir_ctl_t c);
        return !c.ce_n && !c.le_n;
    endfunction

    function automatic logic ctl_drives(dir_ctl_t c);
        return !c.ce_n && !c.oe_n;
    endfunction
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (ctl_loads(ctl)) begin
            held <= src;
        end
    end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] held,
    output logic [W-1:0] dout,
    output logic         den
);
    always_comb begin
        den  = ctl_drives(ctl);
        dout = den ? held : '0;
    end
endmodule

// File: rtl/xcvr_pads.sv
module xcvr_pads #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    inout  tri   [W-1:0] a_pad,
    inout  tri   [W-1:0] b_pad,
    input  logic         a2b_ce_n,
    input  logic         a2b_le_n,
    input  logic         a2b_oe_n,
    input  logic         b2a_ce_n,
    input  logic         b2a_le_n,
    input  logic         b2a_oe_n,
    output logic         contend
);
    logic [W-1:0] a_val, b_val;
    logic         a_en, b_en;

    xcvr_top #(.W(W)) u_core (
        .clk(clk), .rst(rst),
        .a_in(a_pad), .b_in(b_pad),
        .a2b_ce_n(a2b_ce_n), .a2b_le_n(a2b_le_n), .a2b_oe_n(a2b_oe_n),
        .b2a_ce_n(b2a_ce_n), .b2a_le_n(b2a_le_n), .b2a_oe_n(b2a_oe_n),
        .a_out(a_val), .a_drive(a_en),
        .b_out(b_val), .b_drive(b_en),
        .contend(contend)
    );

    assign a_pad = a_en ? a_val : {W{1'bz}};
    assign b_pad = b_en ? b_val : {W{1'bz}};
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a2b_ce_n,
    input  logic         a2b_le_n,
    input  logic         a2b_oe_n,
    input  logic         b2a_ce_n,
    input  logic         b2a_le_n,
    input  logic         b2a_oe_n,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic         contend
);
    dir_ctl_t     ctl  [DIRS];
    logic [W-1:0] src  [DIRS];
    logic [W-1:0] held [DIRS];
    logic [W-1:0] dout [DIRS];
    logic         den  [DIRS];

    // direction 0 carries A toward B, direction 1 carries B toward A
    assign ctl[IDX_A2B] = '{ce_n: a2b_ce_n, le_n: a2b_le_n, oe_n: a2b_oe_n};
    assign ctl[IDX_B2A] = '{ce_n: b2a_ce_n, le_n: b2a_le_n, oe_n: b2a_oe_n};
    assign src[IDX_A2B] = a_in;
    assign src[IDX_B2A] = b_in;

    generate
        for (genvar d = 0; d < DIRS; d++) begin : g_dir
            xcvr_store #(.W(W)) u_store (
                .clk(clk), .rst(rst), .ctl(ctl[d]), .src(src[d]), .held(held[d])
            );
            xcvr_drive #(.W(W)) u_drive (
                .ctl(ctl[d]), .held(held[d]), .dout(dout[d]), .den(den[d])
            );
        end
    endgenerate

    assign b_out   = dout[IDX_A2B];
    assign b_drive = den[IDX_A2B];
    assign a_out   = dout[IDX_B2A];
    assign a_drive = den[IDX_B2A];
    assign contend = den[IDX_A2B] & den[IDX_B2A];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         a2b_ce_n,
    input logic         a2b_le_n,
    input logic         a2b_oe_n,
    input logic         b2a_ce_n,
    input logic         b2a_le_n,
    input logic         b2a_oe_n,
    input logic [W-1:0] a_out,
    input logic         a_drive,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic         contend,
    input logic [W-1:0] q_ab,
    input logic [W-1:0] q_ba
);
    a_r2_load_ab: assert property (@(posedge clk) disable iff (rst)
        (!a2b_ce_n && !a2b_le_n) |=> (q_ab == $past(a_in)));
    a_r3_hold_ab: assert property (@(posedge clk) disable iff (rst)
        (a2b_ce_n || a2b_le_n) |=> $stable(q_ab));
    a_r5_drive_on_b: assert property (@(posedge clk) disable iff (rst)
        (!a2b_ce_n && !a2b_oe_n) |-> (b_drive && b_out == q_ab));
    a_r5_quiet_b: assert property (@(posedge clk) disable iff (rst)
        !b_drive |-> (b_out == '0 && (a2b_ce_n || a2b_oe_n)));
    a_r7_load_ba: assert property (@(posedge clk) disable iff (rst)
        (!b2a_ce_n && !b2a_le_n) |=> (q_ba == $past(b_in)));
    a_r7_hold_ba: assert property (@(posedge clk) disable iff (rst)
        (b2a_ce_n || b2a_le_n) |=> $stable(q_ba));
    a_r7_drive_on_a: assert property (@(posedge clk) disable iff (rst)
        (!b2a_ce_n && !b2a_oe_n) |-> (a_drive && a_out == q_ba));
    a_r7_quiet_a: assert property (@(posedge clk) disable iff (rst)
        !a_drive |-> (a_out == '0 && (b2a_ce_n || b2a_oe_n)));
    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        (a_drive && b_drive) |-> contend);
    a_r8_flag_only: assert property (@(posedge clk) disable iff (rst)
        contend |-> (a_drive && b_drive));
endmodule

bind xcvr_top xcvr_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .a2b_ce_n(a2b_ce_n), .a2b_le_n(a2b_le_n), .a2b_oe_n(a2b_oe_n),
    .b2a_ce_n(b2a_ce_n), .b2a_le_n(b2a_le_n), .b2a_oe_n(b2a_oe_n),
    .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive),
    .contend(contend), .q_ab(held[0]), .q_ba(held[1])
);

// File: tb/tb_xcvr_top.sv
`timescale 1ns/1ps
module tb_xcvr_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] a_in = 8'h00, b_in = 8'h00;
    logic [2:0] ab_c = 3'b111, ba_c = 3'b111; // {ce_n, le_n, oe_n}
    logic [7:0] a_out, b_out;
    logic a_drive, b_drive, contend;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xcvr_top dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .a2b_ce_n(ab_c[2]), .a2b_le_n(ab_c[1]), .a2b_oe_n(ab_c[0]),
        .b2a_ce_n(ba_c[2]), .b2a_le_n(ba_c[1]), .b2a_oe_n(ba_c[0]),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive),
        .contend(contend)
    );

    // behavioural reference: two stored bytes
    int m_ab = 0, m_ba = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_ab = 0; m_ba = 0;
        end else begin
            if (ab_c[2] == 1'b0 && ab_c[1] == 1'b0) m_ab = a_in;
            if (ba_c[2] == 1'b0 && ba_c[1] == 1'b0) m_ba = b_in;
        end
    end

    task automatic check(string tag);
        bit eb, ea;
        logic [18:0] got, exp;
        eb = (ab_c[2] == 1'b0) && (ab_c[0] == 1'b0);
        ea = (ba_c[2] == 1'b0) && (ba_c[0] == 1'b0);
        exp = {(ea ? 8'(m_ba) : 8'h00), ea, (eb ? 8'(m_ab) : 8'h00), eb, ea && eb};
        got = {a_out, a_drive, b_out, b_drive, contend};
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {a_out,a_drive,b_out,b_drive,contend} actual=%h expected=%h",
                     tag, got, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] cab, input logic [2:0] cba, input string tag);
        @(negedge clk);
        a_in = a; b_in = b; ab_c = cab; ba_c = cba;
        #1;
        check(tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: drives enabled right after reset show zero, both sides drive
        cyc(8'h00, 8'h00, 3'b010, 3'b010, "R1");
        cyc(8'h11, 8'h22, 3'b111, 3'b111, "R5");
        // R2: following A
        cyc(8'hA5, 8'h00, 3'b000, 3'b111, "R2");
        cyc(8'h3C, 8'h00, 3'b000, 3'b111, "R2");
        cyc(8'hF0, 8'h00, 3'b000, 3'b111, "R2");
        // R4: load gate rises, last value kept
        cyc(8'h0F, 8'h00, 3'b010, 3'b111, "R4");
        cyc(8'h77, 8'h00, 3'b010, 3'b111, "R4");
        // R6: held value shown while A changes
        cyc(8'h81, 8'h00, 3'b010, 3'b111, "R6");
        // R3: enable high, load gate low
        cyc(8'h99, 8'h00, 3'b100, 3'b111, "R3");
        cyc(8'h55, 8'h00, 3'b010, 3'b111, "R3");
        // R10: drive gate toggles
        cyc(8'h12, 8'h00, 3'b011, 3'b111, "R10");
        cyc(8'h34, 8'h00, 3'b010, 3'b111, "R10");
        cyc(8'h34, 8'h00, 3'b001, 3'b111, "R5");
        // R7: B-to-A mirror
        cyc(8'h00, 8'h6B, 3'b111, 3'b000, "R7");
        cyc(8'h00, 8'hC2, 3'b111, 3'b000, "R7");
        cyc(8'h00, 8'hDE, 3'b111, 3'b010, "R7");
        cyc(8'h00, 8'hEE, 3'b111, 3'b110, "R7");
        cyc(8'h00, 8'h01, 3'b111, 3'b011, "R7");
        cyc(8'h00, 8'h01, 3'b111, 3'b010, "R7");
        // R8: both drive
        cyc(8'h00, 8'h00, 3'b010, 3'b010, "R8");
        // R9: load A-to-B while B-to-A drives its held byte
        cyc(8'hC3, 8'h5A, 3'b000, 3'b010, "R9");
        cyc(8'h3C, 8'hA5, 3'b000, 3'b010, "R9");
        cyc(8'h3C, 8'hA5, 3'b010, 3'b000, "R9");
        cyc(8'h3C, 8'h11, 3'b010, 3'b010, "R9");
        // mixed stimulus
        for (int i = 0; i < 400; i++)
            cyc(8'($urandom), 8'($urandom), 3'($urandom), 3'($urandom), "R3");
        // R1: reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        ab_c = 3'b010; ba_c = 3'b010;
        #1; check("R1");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule